// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block drives the control side of a NAND flash bus for two operations: a page read and an identification read. A request carries the operation, a chip number, a 16-bit column and a 24-bit row. On acceptance the sequencer enables exactly one chip, sends the command and address bytes as latch strobes, and then polls the flash ready/busy line at a fixed interval with a bounded number of attempts. For an identification read it then strobes out five data reads and stores the bytes. The data transfer that follows a page read is handled elsewhere.

Each latch or read strobe is held for `STROBE_CYC` cycles and is followed by one idle cycle. Ready is sampled once every `POLL_DIV` cycles. If it has not been seen after `POLL_LIMIT` samples, the operation ends and a sticky error flag is raised. The state machine has eight states. `ST_IDLE` goes to `ST_CMD` on a request. `ST_CMD` and `ST_ADDR` each go to `ST_GAP` on their final strobe cycle. `ST_GAP` goes to `ST_CMD` or `ST_ADDR` for the next byte, or to `ST_WAIT` after the final byte. `ST_WAIT` goes to `ST_RDATA` (identification, ready seen), or to `ST_FIN` (page read with ready seen, or expiry). `ST_RDATA` goes to `ST_RGAP`. `ST_RGAP` goes back to `ST_RDATA`, or to `ST_FIN` after the fifth byte. `ST_FIN` goes to `ST_IDLE`.

Top module: `nand_read_seq`

## Requirements
- R1: A page read drives `nand_dq_out` with command 0x00 under `nand_cle`, then five bytes under `nand_ale`, then command 0x30 under `nand_cle`.
- R2: The five page-read address bytes are, in order, col[7:0], col[15:8], row[7:0], row[15:8], row[23:16].
- R3: An identification read sends command 0x90, then one address byte 0x00, and after ready issues five `nand_re` strobes. The byte present on `nand_dq_in` in the final cycle of strobe i is stored in `id_bytes[8i+7:8i]`.
- R4: For chip n, `nand_ce` equals only bit n set from the cycle after acceptance up to the done cycle. It is all zero in idle and in the done cycle.
- R5: In `ST_WAIT`, `nand_rdy` is sampled only in the last cycle of each `POLL_DIV`-cycle interval. A high level in any other cycle has no effect.
- R6: If ready is not seen within `POLL_LIMIT` intervals, the block skips any data reads, clears `nand_ce`, pulses `done`, and sets `timeout_err`. The flag stays set through later operations until reset.
- R7: `nand_cle` and `nand_ale` are never high together. Each latch holds `nand_we` and `nand_dq_oe` high for exactly `STROBE_CYC` cycles, followed by one cycle with all strobes low.
- R8: After reset all outputs are low. A request is accepted only in `ST_IDLE`. `busy` is high from the cycle after acceptance through the single-cycle `done` pulse. A request raised while busy is ignored.
- R9: After an identification read, `id_absent` is 1 exactly when the first two stored bytes are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in idle only |
| req_op | input | 1 | 0 = page read, 1 = identification read |
| req_chip | input | 3 | Chip number to enable |
| req_col | input | 16 | Column address |
| req_row | input | 24 | Row (page) address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout_err | output | 1 | Sticky ready-timeout flag |
| id_bytes | output | 40 | Stored identification bytes, byte 0 in the low bits |
| id_absent | output | 1 | First two identification bytes equal |
| nand_ce | output | 8 | One-hot chip enable, active high |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Write strobe, active high |
| nand_re | output | 1 | Read strobe, active high |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Byte read from the bus |
| nand_rdy | input | 1 | Flash ready, high when ready |

## Verification
The hardest region to reach is the polling window. Ready has to be placed relative to sampling points that the ports do not show, including ready arriving on the very last permitted interval and short ready pulses that fall between samples. The bench reference model builds the whole expected trace of each operation, including the ready level to drive in every cycle. It can therefore raise ready exactly on the final sample, glitch it between samples, or hold it low until expiry. It then compares the bus every cycle, including while a second request is raised during a busy operation.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int unsigned COL_BYTES = 2;
    localparam int unsigned ROW_BYTES = 3;
    localparam int unsigned COL_W     = 8 * COL_BYTES;
    localparam int unsigned ROW_W     = 8 * ROW_BYTES;

    localparam logic [7:0] CMD_PAGE_OPEN  = 8'h00;
    localparam logic [7:0] CMD_PAGE_CONF  = 8'h30;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] IDENT_ADDR     = 8'h00;

    localparam logic [2:0] PAGE_LAST_STEP  = 3'(COL_BYTES + ROW_BYTES + 1);
    localparam logic [2:0] IDENT_LAST_STEP = 3'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_GAP,
        ST_WAIT,
        ST_RDATA,
        ST_RGAP,
        ST_FIN
    } seq_state_e;

    typedef enum logic {
        OP_PAGE  = 1'b0,
        OP_IDENT = 1'b1
    } seq_op_e;

    function automatic logic [2:0] last_step(seq_op_e op);
        return (op == OP_PAGE) ? PAGE_LAST_STEP : IDENT_LAST_STEP;
    endfunction

    function automatic logic step_is_cmd(seq_op_e op, logic [2:0] step);
        return (step == 3'd0) || ((op == OP_PAGE) && (step == PAGE_LAST_STEP));
    endfunction

    function automatic logic [7:0] step_byte(seq_op_e op, logic [2:0] step,
                                             logic [COL_W-1:0] col,
                                             logic [ROW_W-1:0] row);
        logic [7:0] b;
        if (op == OP_IDENT) begin
            b = (step == 3'd0) ? CMD_IDENT : IDENT_ADDR;
        end else begin
            unique case (step)
                3'd0:    b = CMD_PAGE_OPEN;
                3'd1:    b = col[7:0];
                3'd2:    b = col[15:8];
                3'd3:    b = row[7:0];
                3'd4:    b = row[15:8];
                3'd5:    b = row[23:16];
                default: b = CMD_PAGE_CONF;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/nrs_strobe_timer.sv
module nrs_strobe_timer #(
    parameter int unsigned LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic last
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = active && (cnt_q == CW'(LEN - 1));
endmodule

// File: rtl/nrs_ready_poll.sv
module nrs_ready_poll #(
    parameter int unsigned DIV   = 4,
    parameter int unsigned LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rdy,
    output logic seen,
    output logic expired
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned IW = $clog2(LIMIT + 1);

    logic [DW-1:0] div_q;
    logic [IW-1:0] ivl_q;
    logic          sample;

    assign sample = en && (div_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ivl_q <= '0;
        end else if (!en) begin
            div_q <= '0;
            ivl_q <= '0;
        end else if (sample) begin
            div_q <= '0;
            ivl_q <= ivl_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign seen    = sample && rdy;
    assign expired = sample && !rdy && (ivl_q == IW'(LIMIT - 1));
endmodule

// File: rtl/nrs_id_capture.sv
module nrs_id_capture #(
    parameter int unsigned NBYTES = 5,
    localparam int unsigned XW    = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap,
    input  logic [XW-1:0]         idx,
    input  logic [7:0]            din,
    output logic [8*NBYTES-1:0]   bytes,
    output logic                  absent
);
    logic [7:0] byte_q [NBYTES];
    logic       fin_q;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[i] <= '0;
            end else if (cap && (idx == XW'(i))) begin
                byte_q[i] <= din;
            end
        end
        assign bytes[8*i +: 8] = byte_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin_q  <= 1'b0;
            absent <= 1'b0;
        end else begin
            fin_q <= cap && (idx == XW'(NBYTES - 1));
            if (fin_q) begin
                absent <= (byte_q[0] == byte_q[1]);
            end
        end
    end
endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
    import nrs_pkg::*;
#(
    parameter int unsigned CE_COUNT   = 8,
    parameter int unsigned STROBE_CYC = 2,
    parameter int unsigned POLL_DIV   = 4,
    parameter int unsigned POLL_LIMIT = 20000,
    parameter int unsigned ID_BYTES   = 5,
    localparam int unsigned CHIP_W    = $clog2(CE_COUNT),
    localparam int unsigned RC_W      = $clog2(ID_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_op,
    input  logic [CHIP_W-1:0]     req_chip,
    input  logic [15:0]           req_col,
    input  logic [23:0]           req_row,
    output logic                  busy,
    output logic                  done,
    output logic                  timeout_err,
    output logic [8*ID_BYTES-1:0] id_bytes,
    output logic                  id_absent,
    output logic [CE_COUNT-1:0]   nand_ce,
    output logic                  nand_cle,
    output logic                  nand_ale,
    output logic                  nand_we,
    output logic                  nand_re,
    output logic [7:0]            nand_dq_out,
    output logic                  nand_dq_oe,
    input  logic [7:0]            nand_dq_in,
    input  logic                  nand_rdy
);

    seq_state_e           state_q, state_d;
    seq_op_e              op_q;
    logic [COL_W-1:0]     col_q;
    logic [ROW_W-1:0]     row_q;
    logic [CE_COUNT-1:0]  ce_q;
    logic [2:0]           step_q;
    logic [RC_W-1:0]      rcnt_q;
    logic                 err_q;

    logic strobe_active;
    logic strobe_last;
    logic poll_en;
    logic poll_seen;
    logic poll_expired;
    logic accept;
    logic capture;

    assign accept        = (state_q == ST_IDLE) && req_valid;
    assign strobe_active = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                           (state_q == ST_RDATA);
    assign poll_en       = (state_q == ST_WAIT);
    assign capture       = (state_q == ST_RDATA) && strobe_last;

    nrs_strobe_timer #(
        .LEN (STROBE_CYC)
    ) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (strobe_active),
        .last   (strobe_last)
    );

    nrs_ready_poll #(
        .DIV   (POLL_DIV),
        .LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (poll_en),
        .rdy     (nand_rdy),
        .seen    (poll_seen),
        .expired (poll_expired)
    );

    nrs_id_capture #(
        .NBYTES (ID_BYTES)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (capture),
        .idx    (rcnt_q),
        .din    (nand_dq_in),
        .bytes  (id_bytes),
        .absent (id_absent)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_CMD;
            end
            ST_CMD, ST_ADDR: begin
                if (strobe_last) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (step_q == last_step(op_q)) begin
                    state_d = ST_WAIT;
                end else if (step_is_cmd(op_q, step_q + 3'd1)) begin
                    state_d = ST_CMD;
                end else begin
                    state_d = ST_ADDR;
                end
            end
            ST_WAIT: begin
                if (poll_seen) begin
                    state_d = (op_q == OP_IDENT) ? ST_RDATA : ST_FIN;
                end else if (poll_expired) begin
                    state_d = ST_FIN;
                end
            end
            ST_RDATA: begin
                if (strobe_last) state_d = ST_RGAP;
            end
            ST_RGAP: begin
                state_d = (rcnt_q == RC_W'(ID_BYTES - 1)) ? ST_FIN : ST_RDATA;
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, step and byte counters, chip enable, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_PAGE;
            col_q  <= '0;
            row_q  <= '0;
            ce_q   <= '0;
            step_q <= '0;
            rcnt_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= seq_op_e'(req_op);
                col_q  <= req_col;
                row_q  <= req_row;
                ce_q   <= CE_COUNT'(1) << req_chip;
                step_q <= '0;
                rcnt_q <= '0;
            end
            if ((state_q == ST_GAP) && (step_q != last_step(op_q))) begin
                step_q <= step_q + 3'd1;
            end
            if ((state_q == ST_RGAP) && (rcnt_q != RC_W'(ID_BYTES - 1))) begin
                rcnt_q <= rcnt_q + 1'b1;
            end
            if ((state_d == ST_FIN) && (state_q != ST_FIN)) begin
                ce_q <= '0;
            end
            if (poll_expired) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_re     = 1'b0;
        nand_dq_out = 8'h00;
        done        = 1'b0;
        unique case (state_q)
            ST_CMD:   nand_cle = 1'b1;
            ST_ADDR:  nand_ale = 1'b1;
            ST_RDATA: nand_re  = 1'b1;
            ST_FIN:   done     = 1'b1;
            default:  ;
        endcase
        nand_we    = nand_cle | nand_ale;
        nand_dq_oe = nand_cle | nand_ale;
        if (nand_dq_oe) begin
            nand_dq_out = step_byte(op_q, step_q, col_q, row_q);
        end
        busy        = (state_q != ST_IDLE);
        nand_ce     = ce_q;
        timeout_err = err_q;
    end

endmodule

// File: rtl/nrs_checker.sv
module nrs_checker #(
    parameter int unsigned CE_COUNT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                timeout_err,
    input logic [CE_COUNT-1:0] nand_ce,
    input logic                nand_cle,
    input logic                nand_ale,
    input logic                nand_we,
    input logic                nand_re,
    input logic                nand_dq_oe
);
    p_latch_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_latch_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> nand_dq_oe);

    p_read_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nand_re |-> (!nand_we && !nand_dq_oe));

    p_ce_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nand_ce));

    p_ce_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |-> (nand_ce == '0));

    p_ce_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (done || $stable(nand_ce)));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind nand_read_seq nrs_checker #(.CE_COUNT(CE_COUNT)) u_nrs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .nand_ce     (nand_ce),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we     (nand_we),
    .nand_re     (nand_re),
    .nand_dq_oe  (nand_dq_oe)
);

// File: tb/sim_nand_read_seq.sv
module sim_nand_read_seq;

    localparam int S = 2;
    localparam int D = 3;
    localparam int L = 6;

    typedef struct packed {
        logic [7:0] ce;
        logic       cle, ale, we, re, oe;
        logic [7:0] dq;
        logic       busy, done, rdy;
        logic [7:0] din;
    } cyc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [2:0]  req_chip = '0;
    logic [15:0] req_col = '0;
    logic [23:0] req_row = '0;
    logic        busy, done, timeout_err, id_absent;
    logic [39:0] id_bytes;
    logic [7:0]  nand_ce, nand_dq_out;
    logic        nand_cle, nand_ale, nand_we, nand_re, nand_dq_oe;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rdy = 1'b0;

    int checks = 0;
    int errors = 0;
    cyc_t q[$];
    logic        exp_err = 1'b0;
    logic [39:0] exp_id = '0;
    logic        exp_abs = 1'b0;

    always #10 clk = ~clk;

    nand_read_seq #(.STROBE_CYC(S), .POLL_DIV(D), .POLL_LIMIT(L)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_chip(req_chip), .req_col(req_col), .req_row(req_row),
        .busy(busy), .done(done), .timeout_err(timeout_err),
        .id_bytes(id_bytes), .id_absent(id_absent), .nand_ce(nand_ce),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we),
        .nand_re(nand_re), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic cyc_t mk(logic [7:0] ce, logic cle, logic ale, logic re,
                                logic [7:0] dq, logic dn, logic rdy, logic [7:0] din);
        cyc_t c;
        c.ce = ce; c.cle = cle; c.ale = ale; c.we = cle | ale; c.re = re;
        c.oe = cle | ale; c.dq = dq; c.busy = 1'b1; c.done = dn;
        c.rdy = rdy; c.din = din;
        return c;
    endfunction

    task automatic cmp(cyc_t e);
        chk("R4 nand_ce", 64'(nand_ce), 64'(e.ce));
        chk("R7 nand_cle", 64'(nand_cle), 64'(e.cle));
        chk("R7 nand_ale", 64'(nand_ale), 64'(e.ale));
        chk("R7 nand_we", 64'(nand_we), 64'(e.we));
        chk("R7 nand_dq_oe", 64'(nand_dq_oe), 64'(e.oe));
        chk("R1/R2 nand_dq_out", 64'(nand_dq_out), 64'(e.dq));
        chk("R3 nand_re", 64'(nand_re), 64'(e.re));
        chk("R8 busy", 64'(busy), 64'(e.busy));
        chk("R8 done", 64'(done), 64'(e.done));
    endtask

    // Build expected trace. k = sample number at which ready is seen, 0 = never.
    task automatic plan(bit op, int chip, logic [15:0] col, logic [23:0] row,
                        int k, bit glitch, logic [39:0] idv);
        logic [7:0] ce = 8'd1 << chip;
        int nl = op ? 2 : 7;
        q.delete();
        for (int j = 0; j < nl; j++) begin
            bit isc = (j == 0) || (!op && j == 6);
            logic [7:0] b;
            if (op) b = (j == 0) ? 8'h90 : 8'h00;
            else begin
                case (j)
                    0: b = 8'h00; 1: b = col[7:0]; 2: b = col[15:8];
                    3: b = row[7:0]; 4: b = row[15:8]; 5: b = row[23:16];
                    default: b = 8'h30;
                endcase
            end
            for (int s = 0; s < S; s++) q.push_back(mk(ce, isc, !isc, 1'b0, b, 1'b0, 1'b0, 8'h00));
            q.push_back(mk(ce, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00));
        end
        if (k > 0) begin
            for (int c = 0; c < k * D; c++) begin
                bit r = (c == k * D - 1) || (glitch && (c % D) != D - 1);
                q.push_back(mk(ce, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, r, 8'h00));
            end
            if (op) begin
                for (int i = 0; i < 5; i++) begin
                    for (int s = 0; s < S; s++)
                        q.push_back(mk(ce, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, idv[8*i +: 8]));
                    q.push_back(mk(ce, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00));
                end
                exp_id  = idv;
                exp_abs = (idv[7:0] == idv[15:8]);
            end
        end else begin
            for (int c = 0; c < L * D; c++) begin
                bit r = glitch && (c % D) != D - 1;
                q.push_back(mk(ce, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, r, 8'h00));
            end
            exp_err = 1'b1;
        end
        q.push_back(mk(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00));
    endtask

    task automatic idle_chk();
        cyc_t z = '0;
        cmp(z);
    endtask

    // R8: poke = index where a stray request is raised for three cycles (-1: none)
    task automatic run(bit op, int chip, logic [15:0] col, logic [23:0] row,
                       int k, bit glitch, logic [39:0] idv, int poke);
        int idx = 0;
        plan(op, chip, col, row, k, glitch, idv);
        req_op = op; req_chip = 3'(chip); req_col = col; req_row = row;
        req_valid = 1'b1;
        #1 idle_chk();
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() > 0) begin
            cyc_t e = q.pop_front();
            nand_rdy   = e.rdy;
            nand_dq_in = e.din;
            if (poke >= 0 && idx >= poke && idx < poke + 3) begin
                req_valid = 1'b1; req_chip = 3'd6; req_op = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            #1 cmp(e);
            @(negedge clk);
            idx++;
        end
        nand_rdy = 1'b0; req_valid = 1'b0;
        #1 idle_chk();
        chk("R6 timeout_err", 64'(timeout_err), 64'(exp_err));
        chk("R3 id_bytes", 64'(id_bytes), 64'(exp_id));
        chk("R9 id_absent", 64'(id_absent), 64'(exp_abs));
        @(negedge clk);
        #1 idle_chk();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 idle_chk();                       // R8 reset state
        chk("R6 timeout_err reset", 64'(timeout_err), 64'd0);
        chk("R9 id_absent reset", 64'(id_absent), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R4 R8: page read, ready on first sample, stray request mid-op
        run(1'b0, 3, 16'h1234, 24'hABCDEF, 1, 1'b0, '0, 4);
        // R5: ready glitches between samples, seen on sample 3
        run(1'b0, 0, 16'h0800, 24'h000040, 3, 1'b1, '0, -1);
        // R5 boundary: ready seen on the last allowed sample
        run(1'b0, 7, 16'hFFFF, 24'h5A5AA5, L, 1'b0, '0, -1);
        // R3 R9: identification, distinct first bytes
        run(1'b1, 0, 16'h0000, 24'h000000, 2, 1'b0, 40'h15A690DC2C, -1);
        // R9: identification with equal first bytes
        run(1'b1, 5, 16'h0000, 24'h000000, 1, 1'b1, 40'h3311EFEFEF, 20);
        // R6: page-read timeout with glitches
        run(1'b0, 2, 16'h00C0, 24'h010203, 0, 1'b1, '0, -1);
        // R6: identification timeout leaves stored bytes unchanged
        run(1'b1, 1, 16'h0000, 24'h000000, 0, 1'b0, '0, -1);
        // R6: flag stays set after a successful operation
        run(1'b0, 4, 16'h4321, 24'h765432, 2, 1'b0, '0, -1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule